// File: doc/BRIEF.md
# Edge Balance Tracker

This block watches a serial bit stream of unbounded length and tells, after every accepted bit, whether the stream has so far contained more rising edges (a 0 followed by a 1), more falling edges (a 1 followed by a 0), or the same number of each. The stream may have any pattern and any density of transitions.

A free-running counter is not needed. Between two rising edges the stream must return to 0, and that return is a falling edge, so the two kinds of edge strictly alternate. The difference between their counts therefore stays within -1, 0 and +1, and a three-state machine holds it exactly.

A bit is accepted on a clock edge where the valid strobe is high. The first bit accepted after reset only sets the stored previous bit and is not counted as an edge. The relation code and a registered copy of the previous accepted bit are driven from flops.

Top module: `edge_balance_fsm`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `balance` is 2'b00 and `prev_bit` is 0. After reset no previous bit is known.
- R2: The first bit accepted after reset loads `prev_bit` with that bit and leaves `balance` at 2'b00, whatever the bit's value.
- R3: An accepted 1 that follows a stored 0 is a rising edge. It changes `balance` from 2'b00 (equal) to 2'b01 (more rising), or from 2'b10 (more falling) to 2'b00.
- R4: An accepted 0 that follows a stored 1 is a falling edge. It changes `balance` from 2'b00 to 2'b10, or from 2'b01 to 2'b00.
- R5: An accepted bit equal to the stored previous bit leaves `balance` unchanged.
- R6: In a cycle where `bit_vld` is low, `balance` and `prev_bit` keep their values.
- R7: `balance` never takes the value 2'b11.
- R8: One clock after each accepted bit, `balance` gives the sign of (rising edges minus falling edges) counted since the bit that first set the stored previous bit: 2'b00 for zero, 2'b01 for positive, 2'b10 for negative. After each accepted bit, `prev_bit` equals that bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_in | input | 1 | Stream data bit |
| bit_vld | input | 1 | High when `bit_in` carries a stream bit |
| balance | output | 2 | Relation code: 00 equal, 01 more rising, 10 more falling |
| prev_bit | output | 1 | Last accepted stream bit |

## Verification
Two functions can fall in the same cycle. One is priming the stored bit with the first bit after reset. The other is edge detection against the value `prev_bit` shows after reset, which is 0. The bench provokes the overlap by sending a 1 as the very first accepted bit after reset, both in the directed sequence and after a reset asserted in the middle of random traffic. The bit must reach `prev_bit`, and `balance` must stay at 2'b00, because an unprimed register may not produce a rising edge.

// File: rtl/edge_balance_fsm.sv
module edge_balance_fsm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_in,
  input  logic       bit_vld,
  output logic [1:0] balance,
  output logic       prev_bit
);

  localparam logic [1:0] EVEN       = 2'b00;
  localparam logic [1:0] RISE_AHEAD = 2'b01;
  localparam logic [1:0] FALL_AHEAD = 2'b10;

  logic [1:0] state, state_nx;
  logic       primed;
  logic       rise, fall;

  assign rise = bit_vld & primed & ~prev_bit &  bit_in;
  assign fall = bit_vld & primed &  prev_bit & ~bit_in;

  always_comb begin
    state_nx = state;
    case (state)
      EVEN:       if (rise) state_nx = RISE_AHEAD;
                  else if (fall) state_nx = FALL_AHEAD;
      RISE_AHEAD: if (fall) state_nx = EVEN;
      FALL_AHEAD: if (rise) state_nx = EVEN;
      default:    state_nx = EVEN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= EVEN;
      primed   <= 1'b0;
      prev_bit <= 1'b0;
    end else begin
      state <= state_nx;
      if (bit_vld) begin
        primed   <= 1'b1;
        prev_bit <= bit_in;
      end
    end
  end

  assign balance = state;

endmodule

module edge_balance_fsm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_in,
  input logic       bit_vld,
  input logic       primed,
  input logic [1:0] balance,
  input logic       prev_bit
);

  p_legal_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    balance != 2'b11);

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> $stable(balance) && $stable(prev_bit));

  p_prime_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && !primed) |=> balance == 2'b00 && prev_bit == $past(bit_in));

  p_rise_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && primed && !prev_bit && bit_in && balance == 2'b00) |=> balance == 2'b01);

  p_rise_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && primed && !prev_bit && bit_in && balance == 2'b10) |=> balance == 2'b00);

  p_fall_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && primed && prev_bit && !bit_in && balance == 2'b00) |=> balance == 2'b10);

  p_fall_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && primed && prev_bit && !bit_in && balance == 2'b01) |=> balance == 2'b00);

  p_same_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && primed && bit_in == prev_bit) |=> $stable(balance));

  p_track_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |=> prev_bit == $past(bit_in));

endmodule

bind edge_balance_fsm edge_balance_fsm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
  .primed(primed), .balance(balance), .prev_bit(prev_bit)
);

// File: tb/edge_balance_fsm_test.sv
`timescale 1ns/1ps
module edge_balance_fsm_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_in = 1'b0;
  logic bit_vld = 1'b0;
  logic [1:0] balance;
  logic prev_bit;

  int checks = 0;
  int errors = 0;
  bit m_primed = 1'b0;
  bit m_prev = 1'b0;
  int m_diff = 0;

  always #2 clk = ~clk;

  edge_balance_fsm uut (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
    .balance(balance), .prev_bit(prev_bit)
  );

  function automatic logic [1:0] code_of(input int d);
    if (d > 0) return 2'b01;
    if (d < 0) return 2'b10;
    return 2'b00;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bit_vld = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk(balance == 2'b00, "R1 balance in reset", balance, 2'b00);
    chk(prev_bit == 1'b0, "R1 prev_bit in reset", {1'b0, prev_bit}, 2'b00);
    rst_n = 1'b1;
    m_primed = 1'b0; m_prev = 1'b0; m_diff = 0;
    @(posedge clk); #1;
    chk(balance == 2'b00, "R1 balance after release", balance, 2'b00);
    chk(prev_bit == 1'b0, "R1 prev_bit after release", {1'b0, prev_bit}, 2'b00);
  endtask

  task automatic step(input bit v, input bit b);
    string tag;
    bit_vld = v; bit_in = b;
    @(posedge clk); #1;
    if (!v) tag = "R6";
    else if (!m_primed) tag = "R2";
    else if (!m_prev && b) tag = "R3";
    else if (m_prev && !b) tag = "R4";
    else tag = "R5";
    if (v) begin
      if (m_primed && !m_prev && b) m_diff++;
      if (m_primed && m_prev && !b) m_diff--;
      m_primed = 1'b1;
      m_prev = b;
    end
    chk(balance == code_of(m_diff), {tag, " R8 balance"}, balance, code_of(m_diff));
    chk(prev_bit == m_prev, {tag, " R8 prev_bit"}, {1'b0, prev_bit}, {1'b0, m_prev});
    chk(balance != 2'b11, "R7 illegal code", balance, 2'b00);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired act=%b exp=%b", 2'b00, 2'b01);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    do_reset();
    step(1, 1);
    step(0, 0);
    step(1, 0);
    step(1, 0);
    step(1, 1);
    step(1, 1);
    step(0, 0);
    step(0, 1);
    do_reset();
    step(1, 0);
    step(1, 1);
    step(0, 0);
    step(1, 0);
    step(1, 1);
    step(1, 0);
    for (int i = 0; i < 3000; i++) begin
      if (i == 1500) begin
        do_reset();
        step(1, 1);
      end
      step(($urandom % 4) != 0, $urandom % 2);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule